// File: doc/BRIEF.md
# Serial Panel Command Interpreter

This block is the slave-side decoder of a small LCD driver that receives full-duplex serial words. Every accepted word is one of two things. It is either a new command byte or a parameter for the command that is still waiting for arguments. In the same transfer the block returns one byte from a short response buffer, which earlier read commands filled. The block holds the panel mode flags: sleep, partial, normal, vertical scroll, invert, display-on, tearing-effect, booster and a two-bit gamma index. It also holds a self-diagnosis byte.

Read commands rebuild the whole response buffer from the live flags, using fixed bit packings. The byte that goes out with a word always comes from the buffer and pointer as they stood before that word was decoded. A word is taken on a clock edge where `word_valid` is high, `cs_n` is low and `word_len` is no larger than the widest legal word. Only bits [7:0] of the word are decoded. Commands the block does not support are accepted and have no effect.

Top module: `lcd_cmd_decoder`

## Requirements
- R1: After power-on reset, `byte_out` = 0x00 and `len_err` = 0. The flags start as sleep=1, normal=1, display-on=1, with all other flags and gamma at 0 and the self-diagnosis byte at 0x00. A power-mode read (0x0A) therefore returns 0x5C.
- R2: Each taken word updates `byte_out` at the edge that takes it. The new value is the buffer byte at the read pointer as it stood before that word, or 0x00 if the pointer is past the 4-byte buffer. The pointer then advances by one. A read command sets the pointer to 0 and reloads all 4 bytes, filling unused bytes with 0x00. The buffer is empty after reset.
- R3: Command 0x04 loads the ID bytes 0x83, 0x8F, 0x03 in that order. Commands 0xDA, 0xDB and 0xDC each load one byte: 0x83, 0x8F and 0x03 respectively.
- R4: Command 0x09 loads four bytes. Byte 0 is booster<<7. Byte 1 is 0x50|partial<<2|sleep<<1|normal. Byte 2 is vscroll<<7|invert<<5|on<<2|te<<1. Byte 3 is gamma<<6.
- R5: The single-byte reads return the following values. 0x0A returns booster<<7|sleep<<6|partial<<5|sleep<<4|normal<<3|on<<2. 0x0C returns 0x05. 0x0D returns vscroll<<7|invert<<5|gamma. 0x0E returns te<<7. 0x0B returns 0x00. 0x06, 0x07 and 0x08 return 0x01. Command 0xBD loads 0x00 then 0x01.
- R6: Command 0x10 sets sleep. Command 0x11 clears sleep and inverts bit 6 of the self-diagnosis byte, which command 0x0F reads back.
- R7: Exactly one of partial, normal and vertical scroll is set at all times. Command 0x12 selects partial, 0x13 selects normal and 0x37 selects vertical scroll.
- R8: Command 0x26 takes one parameter. Gamma becomes the index of the lowest set bit in the parameter's bits [3:0]. A parameter with zero in those bits leaves gamma unchanged.
- R9: Command 0x35 takes one parameter, and te is set when that parameter arrives. Command 0x34 clears te.
- R10: Command 0x25 takes one parameter, and 0xB0, 0xB1 and 0xC2 each take two. These parameters are ignored, and a parameter word is never decoded as a command.
- R11: A clock edge with `cs_n` high drops any outstanding parameters, so the next taken word is decoded as a command.
- R12: A word whose `word_len` exceeds 9 is not taken. It pulses `len_err` high for one cycle and leaves the pointer, the flags and `byte_out` unchanged.
- R13: Command 0x01 sets normal and display-on, and clears partial, vertical scroll, invert and gamma. Unsupported commands (for example 0x2C or 0xFF) change no flag.
- R14: Commands 0x03 and 0x02 set and clear booster, 0x21 and 0x20 set and clear invert, and 0x29 and 0x28 set and clear display-on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| word_valid | input | 1 | A word transfer completes in this cycle |
| word_len | input | LEN_W (4) | Bit count of the transfer |
| word_in | input | MAX_BITS (9) | Received word; bits [7:0] are decoded |
| byte_out | output | 8 | Byte returned with the latest taken word |
| len_err | output | 1 | One-cycle pulse after an over-wide word |

## Verification
Status and power-mode reads are run after distinct flag combinations (reset, booster+invert+gamma+te, partial, scroll, after soft reset), so a wrong bit position or a swapped flag shows up in at least one packing. Reading the buffer word by word, issuing a new read before the old one is drained, and reading past the fourth byte separate the "returned before decode" ordering from an off-by-one pointer. Parameter words chosen to be valid commands (0x10, 0x11), a chip-select gap inside a pending command, and an over-wide sleep word show whether parameters, deselection and length errors are kept apart from command decoding.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

   typedef struct packed {
      logic       sleep;
      logic       booster;
      logic       partial;
      logic       normal;
      logic       vscroll;
      logic       invert;
      logic       disp_on;
      logic       te;
      logic [1:0] gamma;
      logic [7:0] diag;
   } lcd_flags_t;

   localparam lcd_flags_t FLAGS_RESET = '{sleep: 1'b1, booster: 1'b0, partial: 1'b0,
                                          normal: 1'b1, vscroll: 1'b0, invert: 1'b0,
                                          disp_on: 1'b1, te: 1'b0, gamma: 2'd0,
                                          diag: 8'h00};

   // command codes
   localparam logic [7:0] OP_SOFT_RST  = 8'h01;
   localparam logic [7:0] OP_BOOST_OFF = 8'h02;
   localparam logic [7:0] OP_BOOST_ON  = 8'h03;
   localparam logic [7:0] OP_RD_ID     = 8'h04;
   localparam logic [7:0] OP_RD_PIX_R  = 8'h06;
   localparam logic [7:0] OP_RD_PIX_G  = 8'h07;
   localparam logic [7:0] OP_RD_PIX_B  = 8'h08;
   localparam logic [7:0] OP_RD_STAT   = 8'h09;
   localparam logic [7:0] OP_RD_PWR    = 8'h0A;
   localparam logic [7:0] OP_RD_ACCESS = 8'h0B;
   localparam logic [7:0] OP_RD_PIXFMT = 8'h0C;
   localparam logic [7:0] OP_RD_IMAGE  = 8'h0D;
   localparam logic [7:0] OP_RD_SIGNAL = 8'h0E;
   localparam logic [7:0] OP_RD_DIAG   = 8'h0F;
   localparam logic [7:0] OP_SLEEP_IN  = 8'h10;
   localparam logic [7:0] OP_SLEEP_OUT = 8'h11;
   localparam logic [7:0] OP_PARTIAL   = 8'h12;
   localparam logic [7:0] OP_NORMAL    = 8'h13;
   localparam logic [7:0] OP_INV_OFF   = 8'h20;
   localparam logic [7:0] OP_INV_ON    = 8'h21;
   localparam logic [7:0] OP_CONTRAST  = 8'h25;
   localparam logic [7:0] OP_GAMMA     = 8'h26;
   localparam logic [7:0] OP_DISP_OFF  = 8'h28;
   localparam logic [7:0] OP_DISP_ON   = 8'h29;
   localparam logic [7:0] OP_TE_OFF    = 8'h34;
   localparam logic [7:0] OP_TE_ON     = 8'h35;
   localparam logic [7:0] OP_VSCROLL   = 8'h37;
   localparam logic [7:0] OP_CLK_INT   = 8'hB0;
   localparam logic [7:0] OP_CLK_EXT   = 8'hB1;
   localparam logic [7:0] OP_RD_MISC   = 8'hBD;
   localparam logic [7:0] OP_IF_MODE   = 8'hC2;
   localparam logic [7:0] OP_RD_ID_HI  = 8'hDA;
   localparam logic [7:0] OP_RD_ID_MID = 8'hDB;
   localparam logic [7:0] OP_RD_ID_LO  = 8'hDC;

   function automatic logic [1:0] params_needed(input logic [7:0] op);
      case (op)
         OP_GAMMA, OP_TE_ON, OP_CONTRAST:    params_needed = 2'd1;
         OP_CLK_INT, OP_CLK_EXT, OP_IF_MODE: params_needed = 2'd2;
         default:                            params_needed = 2'd0;
      endcase
   endfunction

   function automatic logic [1:0] lowest_set(input logic [3:0] n);
      casez (n)
         4'b???1: lowest_set = 2'd0;
         4'b??10: lowest_set = 2'd1;
         4'b?100: lowest_set = 2'd2;
         default: lowest_set = 2'd3;
      endcase
   endfunction

endpackage

// File: rtl/lcdc_mode_regs.sv
module lcdc_mode_regs
   import lcdc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_stb,
   input  logic [7:0] cmd_code,
   input  logic       par_stb,
   input  logic [7:0] par_cmd,
   input  logic [7:0] par_data,
   output lcd_flags_t flags
);

   lcd_flags_t f_q, f_d;

   always_comb begin
      f_d = f_q;
      if (cmd_stb) begin
         case (cmd_code)
            OP_SOFT_RST: begin
               f_d.normal  = 1'b1;
               f_d.partial = 1'b0;
               f_d.vscroll = 1'b0;
               f_d.invert  = 1'b0;
               f_d.disp_on = 1'b1;
               f_d.gamma   = 2'd0;
            end
            OP_BOOST_OFF: f_d.booster = 1'b0;
            OP_BOOST_ON:  f_d.booster = 1'b1;
            OP_SLEEP_IN:  f_d.sleep   = 1'b1;
            OP_SLEEP_OUT: begin
               f_d.sleep   = 1'b0;
               f_d.diag[6] = ~f_q.diag[6];
            end
            OP_PARTIAL: {f_d.partial, f_d.normal, f_d.vscroll} = 3'b100;
            OP_NORMAL:  {f_d.partial, f_d.normal, f_d.vscroll} = 3'b010;
            OP_VSCROLL: {f_d.partial, f_d.normal, f_d.vscroll} = 3'b001;
            OP_INV_OFF:  f_d.invert  = 1'b0;
            OP_INV_ON:   f_d.invert  = 1'b1;
            OP_DISP_OFF: f_d.disp_on = 1'b0;
            OP_DISP_ON:  f_d.disp_on = 1'b1;
            OP_TE_OFF:   f_d.te      = 1'b0;
            default: ;
         endcase
      end else if (par_stb) begin
         case (par_cmd)
            OP_GAMMA: if (par_data[3:0] != 4'h0) f_d.gamma = lowest_set(par_data[3:0]);
            OP_TE_ON: f_d.te = 1'b1;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) f_q <= FLAGS_RESET;
      else        f_q <= f_d;
   end

   assign flags = f_q;

endmodule

// File: rtl/lcdc_resp_buf.sv
module lcdc_resp_buf #(
   parameter int DEPTH = 4,
   localparam int PTR_W = $clog2(DEPTH + 1),
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  adv,
   input  logic                  load,
   input  logic [DEPTH-1:0][7:0] load_data,
   output logic [7:0]            rd_byte,
   output logic [PTR_W-1:0]      rd_ptr
);

   logic [DEPTH-1:0][7:0] mem_q;
   logic [PTR_W-1:0]      ptr_q;
   logic                  in_range;

   assign in_range = (ptr_q < PTR_W'(DEPTH));
   assign rd_byte  = in_range ? mem_q[ptr_q[IDX_W-1:0]] : 8'h00;
   assign rd_ptr   = ptr_q;

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            mem_q[g] <= 8'h00;
         else if (adv && load)  mem_q[g] <= load_data[g];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 ptr_q <= PTR_W'(DEPTH);
      else if (adv && load)       ptr_q <= '0;
      else if (adv && in_range)   ptr_q <= ptr_q + 1'b1;
   end

endmodule

// File: rtl/lcd_cmd_decoder.sv
module lcd_cmd_decoder
   import lcdc_pkg::*;
#(
   parameter int          MAX_BITS = 9,
   parameter int          LEN_W    = 4,
   parameter int          DEPTH    = 4,
   parameter logic [23:0] DEV_ID   = 24'h838F03,
   localparam int PTR_W = $clog2(DEPTH + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cs_n,
   input  logic                word_valid,
   input  logic [LEN_W-1:0]    word_len,
   input  logic [MAX_BITS-1:0] word_in,
   output logic [7:0]          byte_out,
   output logic                len_err
);

   if (MAX_BITS < 8) begin : g_bad_width
      $error("MAX_BITS must hold a full command byte");
   end
   if (DEPTH < 4) begin : g_bad_depth
      $error("DEPTH must hold the four-byte status response");
   end
   if ((2 ** LEN_W) <= MAX_BITS + 1) begin : g_bad_len
      $error("LEN_W cannot express an over-wide transfer");
   end

   logic                  wide, take, cmd_stb, par_stb, load;
   logic [7:0]            wbyte, cur_cmd, rd_byte;
   logic [1:0]            pcnt;
   logic [PTR_W-1:0]      rd_ptr;
   logic [DEPTH-1:0][7:0] ld;
   lcd_flags_t            flags;

   assign wbyte   = word_in[7:0];
   assign wide    = word_valid && !cs_n && (word_len > LEN_W'(MAX_BITS));
   assign take    = word_valid && !cs_n && !wide;
   assign cmd_stb = take && (pcnt == 2'd0);
   assign par_stb = take && (pcnt == 2'd1);

   // parameter countdown
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt    <= 2'd0;
         cur_cmd <= 8'h00;
      end else if (cs_n) begin
         pcnt    <= 2'd0;
      end else if (take) begin
         if (pcnt != 2'd0) pcnt <= pcnt - 1'b1;
         else begin
            cur_cmd <= wbyte;
            pcnt    <= params_needed(wbyte);
         end
      end
   end

   // response builder from the flags as they stand
   always_comb begin
      load = 1'b0;
      ld   = '0;
      if (cmd_stb) begin
         load = 1'b1;
         case (wbyte)
            OP_RD_ID: begin
               ld[0] = DEV_ID[23:16];
               ld[1] = DEV_ID[15:8];
               ld[2] = DEV_ID[7:0];
            end
            OP_RD_PIX_R, OP_RD_PIX_G, OP_RD_PIX_B: ld[0] = 8'h01;
            OP_RD_STAT: begin
               ld[0] = {flags.booster, 7'b0};
               ld[1] = {4'h5, 1'b0, flags.partial, flags.sleep, flags.normal};
               ld[2] = {flags.vscroll, 1'b0, flags.invert, 2'b0,
                        flags.disp_on, flags.te, 1'b0};
               ld[3] = {flags.gamma, 6'b0};
            end
            OP_RD_PWR: ld[0] = {flags.booster, flags.sleep, flags.partial, flags.sleep,
                                flags.normal, flags.disp_on, 2'b0};
            OP_RD_ACCESS: ld[0] = 8'h00;
            OP_RD_PIXFMT: ld[0] = 8'h05;
            OP_RD_IMAGE:  ld[0] = {flags.vscroll, 1'b0, flags.invert, 3'b0, flags.gamma};
            OP_RD_SIGNAL: ld[0] = {flags.te, 7'b0};
            OP_RD_DIAG:   ld[0] = flags.diag;
            OP_RD_MISC:   ld[1] = 8'h01;
            OP_RD_ID_HI:  ld[0] = DEV_ID[23:16];
            OP_RD_ID_MID: ld[0] = DEV_ID[15:8];
            OP_RD_ID_LO:  ld[0] = DEV_ID[7:0];
            default:      load  = 1'b0;
         endcase
      end
   end

   lcdc_resp_buf #(.DEPTH(DEPTH)) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .adv       (take),
      .load      (load),
      .load_data (ld),
      .rd_byte   (rd_byte),
      .rd_ptr    (rd_ptr)
   );

   lcdc_mode_regs u_modes (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_stb  (cmd_stb),
      .cmd_code (wbyte),
      .par_stb  (par_stb),
      .par_cmd  (cur_cmd),
      .par_data (wbyte),
      .flags    (flags)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_out <= 8'h00;
         len_err  <= 1'b0;
      end else begin
         len_err <= wide;
         if (take) byte_out <= rd_byte;
      end
   end

endmodule

// File: rtl/lcdc_checker.sv
module lcdc_checker
   import lcdc_pkg::*;
#(
   parameter int MAX_BITS = 9,
   parameter int LEN_W    = 4,
   parameter int DEPTH    = 4,
   localparam int PTR_W = $clog2(DEPTH + 1)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cs_n,
   input logic                word_valid,
   input logic [LEN_W-1:0]    word_len,
   input logic [MAX_BITS-1:0] word_in,
   input logic [7:0]          byte_out,
   input logic                len_err,
   input logic [1:0]          pcnt,
   input logic [PTR_W-1:0]    rd_ptr,
   input lcd_flags_t          flags
);

   logic sel_word, over, taken;
   assign sel_word = word_valid && !cs_n;
   assign over     = word_len > LEN_W'(MAX_BITS);
   assign taken    = sel_word && !over;

   p_empty_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (taken && rd_ptr >= PTR_W'(DEPTH)) |=> (byte_out == 8'h00));

   p_sleep_in_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (taken && pcnt == 2'd0 && word_in[7:0] == 8'h10) |=> flags.sleep);

   p_mode_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({flags.partial, flags.normal, flags.vscroll}) == 1);

   p_param_no_decode_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (taken && pcnt != 2'd0) |=> ($stable(flags.sleep) && $stable(flags.booster) &&
                                   $stable(flags.disp_on) && $stable(flags.invert)));

   p_deselect_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> (pcnt == 2'd0));

   p_wide_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_word && over) |=> ($stable(rd_ptr) && $stable(flags) && $stable(byte_out) && len_err));

endmodule

bind lcd_cmd_decoder lcdc_checker #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W), .DEPTH(DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cs_n       (cs_n),
   .word_valid (word_valid),
   .word_len   (word_len),
   .word_in    (word_in),
   .byte_out   (byte_out),
   .len_err    (len_err),
   .pcnt       (pcnt),
   .rd_ptr     (rd_ptr),
   .flags      (flags)
);

// File: tb/lcd_cmd_decoder_tb.sv
`timescale 1ns/1ps
module lcd_cmd_decoder_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1;
   logic       word_valid = 1'b0;
   logic [3:0] word_len = 4'd9;
   logic [8:0] word_in = '0;
   logic [7:0] byte_out;
   logic       len_err;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   // requirement model of the flags
   logic m_sleep = 1, m_boost = 0, m_part = 0, m_norm = 1, m_vscr = 0;
   logic m_inv = 0, m_on = 1, m_te = 0;
   logic [1:0] m_gam = 0;

   always #2.5 clk = ~clk;

   lcd_cmd_decoder dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .word_valid(word_valid),
      .word_len(word_len), .word_in(word_in), .byte_out(byte_out), .len_err(len_err)
   );

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   task automatic xfer_len(input logic [8:0] w, input logic [3:0] len, output logic [7:0] got);
      @(negedge clk);
      cs_n = 1'b0; word_valid = 1'b1; word_in = w; word_len = len;
      @(negedge clk);
      word_valid = 1'b0;
      got = byte_out;
   endtask

   task automatic xfer(input logic [8:0] w, output logic [7:0] got);
      xfer_len(w, 4'd9, got);
   endtask

   task automatic send(input logic [8:0] w);
      logic [7:0] g;
      xfer(w, g);
   endtask

   task automatic read1(input string req, input logic [7:0] op, input logic [7:0] exp);
      logic [7:0] g;
      send(op);
      xfer(9'h000, g);
      chk(req, g, exp);
   endtask

   task automatic read_status(input string req);
      logic [7:0] g;
      logic [7:0] e [4];
      e[0] = {m_boost, 7'b0};
      e[1] = 8'h50 | {5'b0, m_part, m_sleep, m_norm};
      e[2] = {m_vscr, 1'b0, m_inv, 2'b0, m_on, m_te, 1'b0};
      e[3] = {m_gam, 6'b0};
      send(9'h009);
      for (int i = 0; i < 4; i++) begin
         xfer(9'h000, g);
         chk(req, g, e[i]);
      end
   endtask

   task automatic t_reset;
      chk("R1 byte_out", byte_out, 8'h00);
      chk("R1 len_err", {7'b0, len_err}, 8'h00);
      read1("R1 power after reset", 8'h0A, 8'h5C);
      read_status("R1 status after reset");
   endtask

   task automatic t_pointer;
      logic [7:0] g;
      send(9'h004);
      xfer(9'h0DA, g);
      chk("R2 old byte returned with new read", g, 8'h83);
      xfer(9'h000, g);
      chk("R2 reload restarts pointer", g, 8'h83);
      send(9'h009);
      for (int i = 0; i < 4; i++) send(9'h000);
      xfer(9'h000, g);
      chk("R2 past end", g, 8'h00);
   endtask

   task automatic t_ident;
      logic [7:0] g;
      send(9'h004);
      xfer(9'h000, g); chk("R3 id0", g, 8'h83);
      xfer(9'h000, g); chk("R3 id1", g, 8'h8F);
      xfer(9'h000, g); chk("R3 id2", g, 8'h03);
      read1("R3 id high", 8'hDA, 8'h83);
      read1("R3 id mid", 8'hDB, 8'h8F);
      read1("R3 id low", 8'hDC, 8'h03);
   endtask

   task automatic t_flags_status;
      send(9'h003); m_boost = 1;
      send(9'h021); m_inv = 1;
      send(9'h026); send(9'h008); m_gam = 2'd3;
      send(9'h035); send(9'h000); m_te = 1;
      read_status("R4 status booster/invert/gamma/te");
      read1("R5 power", 8'h0A, 8'hDC);
      read1("R5 pixel format", 8'h0C, 8'h05);
      read1("R5 image", 8'h0D, 8'h23);
      read1("R5 signal", 8'h0E, 8'h80);
      read1("R5 access", 8'h0B, 8'h00);
      read1("R5 pixel colour", 8'h07, 8'h01);
      read1("R5 misc", 8'hBD, 8'h00);
      send(9'h034); m_te = 0;
      read1("R9 te off", 8'h0E, 8'h00);
      send(9'h002); m_boost = 0;
      send(9'h020); m_inv = 0;
      send(9'h028); m_on = 0;
      read_status("R14 booster/invert/display off");
      send(9'h029); m_on = 1;
      read_status("R14 display on");
   endtask

   task automatic t_gamma;
      send(9'h026); send(9'h0F0);
      read_status("R8 zero nibble keeps gamma");
      send(9'h026); send(9'h006); m_gam = 2'd1;
      read_status("R8 lowest set bit");
   endtask

   task automatic t_sleep;
      send(9'h011); m_sleep = 0;
      read1("R6 diag toggled", 8'h0F, 8'h40);
      read1("R6 power sleep out", 8'h0A, 8'h0C);
      send(9'h011);
      read1("R6 diag toggled back", 8'h0F, 8'h00);
      send(9'h010); m_sleep = 1;
      read_status("R6 sleep in");
   endtask

   task automatic t_modes;
      send(9'h012); {m_part, m_norm, m_vscr} = 3'b100;
      read_status("R7 partial");
      send(9'h037); {m_part, m_norm, m_vscr} = 3'b001;
      read_status("R7 vscroll");
      send(9'h013); {m_part, m_norm, m_vscr} = 3'b010;
      read_status("R7 normal");
   endtask

   task automatic t_params;
      send(9'h011); m_sleep = 0;
      send(9'h0B0); send(9'h010); send(9'h003);
      read_status("R10 two ignored params");
      send(9'h025); send(9'h010);
      read_status("R10 one ignored param");
      send(9'h0C2); send(9'h021); send(9'h028);
      read_status("R10 if-mode params");
   endtask

   task automatic t_deselect;
      send(9'h026);
      @(negedge clk); cs_n = 1'b1;
      @(negedge clk); cs_n = 1'b0;
      send(9'h010); m_sleep = 1;
      read_status("R11 deselect drops pending param");
   endtask

   task automatic t_wide;
      logic [7:0] g;
      send(9'h011); m_sleep = 0;
      send(9'h004);
      xfer(9'h000, g); chk("R12 setup", g, 8'h83);
      xfer_len(9'h010, 4'd10, g);
      chk("R12 byte_out held", g, 8'h83);
      chk("R12 len_err pulse", {7'b0, len_err}, 8'h01);
      xfer(9'h000, g); chk("R12 pointer not advanced", g, 8'h8F);
      chk("R12 len_err cleared", {7'b0, len_err}, 8'h00);
      read_status("R12 wide sleep word ignored");
   endtask

   task automatic t_softreset;
      send(9'h021); m_inv = 1;
      send(9'h012); {m_part, m_norm, m_vscr} = 3'b100;
      send(9'h028); m_on = 0;
      send(9'h026); send(9'h004); m_gam = 2'd2;
      send(9'h003); m_boost = 1;
      send(9'h02C); send(9'h0FF);
      read_status("R13 unsupported commands ignored");
      send(9'h001);
      m_inv = 0; {m_part, m_norm, m_vscr} = 3'b010; m_on = 1; m_gam = 0;
      read_status("R13 soft reset");
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_pointer();
      t_ident();
      t_flags_status();
      t_gamma();
      t_sleep();
      t_modes();
      t_params();
      t_deselect();
      t_wide();
      t_softreset();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule